// File: doc/BRIEF.md
# Register Rename Map with Free List

This block sits at the front of a small out-of-order core and renames one instruction per cycle, in program order. Each instruction names two logical source registers and one logical destination register. The block returns the physical tag that holds each source value at rename time. It also returns a freshly allocated physical tag for the destination, taken from a pool that is larger than the logical register set. Because each write gets a fresh tag, false write-after-read and write-after-write ordering disappears. True read-after-write dependences are kept, because later readers see the new tag.

Internally there are three structures:
- a logical-to-physical map table;
- a circular free list of unused physical tags;
- a program-order retire queue that records, for each in-flight instruction, the tag its destination pointed to before renaming.

A retire pulse releases the oldest recorded tag back to the free list. While no tag is free, the block holds `ren_ready` low and leaves its state untouched.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical tag i (tags are numbered from 0, `PHYS_N`=8 and `LOG_N`=4 by default), `ren_ready` is high, and tags `LOG_N`..`PHYS_N`-1 are handed out in ascending order.
- R2: `ren_psrc_a`/`ren_psrc_b` show the map entries of `ren_lsrc_a`/`ren_lsrc_b` as they stand in the rename cycle, and `ren_pdst` shows the oldest tag on the free list. All three are combinational in that cycle.
- R3: A rename (`ren_valid` and `ren_ready` both high) updates the destination's map entry, so an instruction renamed in the very next cycle that reads that logical register gets the new tag.
- R4: When an instruction's source equals its own destination, the source reads the mapping from before that instruction's update.
- R5: The free list is first-in first-out: released tags are allocated in the order they were released, after the tags already on the list.
- R6: Each pulse of `ret_valid` retires the oldest in-flight instruction and releases the tag that its logical destination mapped to before it was renamed.
- R7: `ret_valid` with no instruction in flight has no effect.
- R8: When the free list is empty, `ren_ready` is low, and an instruction presented then changes neither the map nor the free list.
- R9: A rename and a retire may occur in the same cycle. A tag released in a cycle can be allocated from the next cycle on, but not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is presented for renaming |
| ren_lsrc_a | input | $clog2(LOG_N) | Logical source A |
| ren_lsrc_b | input | $clog2(LOG_N) | Logical source B |
| ren_ldst | input | $clog2(LOG_N) | Logical destination |
| ren_ready | output | 1 | A physical tag is free; rename takes effect this cycle |
| ren_psrc_a | output | $clog2(PHYS_N) | Physical tag for source A |
| ren_psrc_b | output | $clog2(PHYS_N) | Physical tag for source B |
| ren_pdst | output | $clog2(PHYS_N) | Newly allocated physical tag for the destination |
| ret_valid | input | 1 | Oldest in-flight instruction retires |

## Verification
A corrupted map entry shows up on the source tag outputs of the first later instruction that reads that logical register. A misplaced free-list or retire-queue pointer shows up as a wrong `ren_pdst` once the affected slot reaches the head of the list. That can be up to a full pool's worth of renames later, so the stimulus cycles the pool many times over. A lost or duplicated tag breaks the balance between free and in-flight tags, and it appears as `ren_ready` dropping too early or too late. The bench compares every cycle's outputs against a reference model built from the requirements, including stalls and simultaneous rename and retire.

// File: rtl/rn_pkg.sv
package rn_pkg;
    // Bits needed to index n items, never less than one.
    function automatic int unsigned rn_bits(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rn_tag_fifo.sv
module rn_tag_fifo
    import rn_pkg::*;
#(
    parameter int unsigned DEPTH     = 4,
    parameter int unsigned TW        = 3,
    parameter bit          INIT_FULL = 1'b0,
    parameter int unsigned INIT_BASE = 0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              push,
    input  logic [TW-1:0]                     push_tag,
    input  logic                              pop,
    output logic [TW-1:0]                     head_tag,
    output logic                              empty,
    output logic                              full,
    output logic [rn_bits(DEPTH+1)-1:0]       count
);
    localparam int unsigned PW = rn_bits(DEPTH);
    localparam int unsigned CW = rn_bits(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][TW-1:0] mem;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q, st_rst;

    function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_rst = '0;
        if (INIT_FULL) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_rst.mem[i] = TW'(INIT_BASE + i);
            end
            st_rst.cnt = CW'(DEPTH);
        end
    end

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_tag;
            st_d.wr           = ptr_inc(st_q.wr);
        end
        if (pop) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        if (push && !pop) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop && !push) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_tag = st_q.mem[st_q.rd];
    assign empty    = (st_q.cnt == '0);
    assign full     = (st_q.cnt == CW'(DEPTH));
    assign count    = st_q.cnt;
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
    import rn_pkg::*;
#(
    parameter int unsigned LOG_N = 4,
    parameter int unsigned TW    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [rn_bits(LOG_N)-1:0] rd_a_idx,
    input  logic [rn_bits(LOG_N)-1:0] rd_b_idx,
    input  logic [rn_bits(LOG_N)-1:0] rd_c_idx,
    output logic [TW-1:0]             rd_a_tag,
    output logic [TW-1:0]             rd_b_tag,
    output logic [TW-1:0]             rd_c_tag,
    input  logic                      wr_en,
    input  logic [rn_bits(LOG_N)-1:0] wr_idx,
    input  logic [TW-1:0]             wr_tag,
    output logic [LOG_N*TW-1:0]       map_flat
);
    typedef struct packed {
        logic [LOG_N-1:0][TW-1:0] ent;
    } map_st_t;

    map_st_t st_d, st_q, st_rst;

    always_comb begin
        for (int i = 0; i < LOG_N; i++) begin
            st_rst.ent[i] = TW'(i);
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx] = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    // Reads see the registered table: same-cycle writes are not forwarded.
    assign rd_a_tag = st_q.ent[rd_a_idx];
    assign rd_b_tag = st_q.ent[rd_b_idx];
    assign rd_c_tag = st_q.ent[rd_c_idx];
    assign map_flat = st_q.ent;
endmodule

// File: rtl/reg_rename_unit.sv
module reg_rename_unit
    import rn_pkg::*;
#(
    parameter int unsigned LOG_N  = 4,
    parameter int unsigned PHYS_N = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ren_valid,
    input  logic [rn_bits(LOG_N)-1:0]  ren_lsrc_a,
    input  logic [rn_bits(LOG_N)-1:0]  ren_lsrc_b,
    input  logic [rn_bits(LOG_N)-1:0]  ren_ldst,
    output logic                       ren_ready,
    output logic [rn_bits(PHYS_N)-1:0] ren_psrc_a,
    output logic [rn_bits(PHYS_N)-1:0] ren_psrc_b,
    output logic [rn_bits(PHYS_N)-1:0] ren_pdst,
    input  logic                       ret_valid
);
    localparam int unsigned TW   = rn_bits(PHYS_N);
    localparam int unsigned POOL = PHYS_N - LOG_N;
    localparam int unsigned CW   = rn_bits(POOL + 1);

    logic          fl_empty, fl_full, rq_empty, rq_full;
    logic [CW-1:0] fl_cnt, rq_cnt;
    logic [TW-1:0] fl_head, rq_head, old_dst_tag;
    logic          ren_fire, ret_go;
    logic [LOG_N*TW-1:0] map_flat;

    assign ren_ready = !fl_empty;
    assign ren_fire  = ren_valid && ren_ready;
    assign ret_go    = ret_valid && !rq_empty;
    assign ren_pdst  = fl_head;

    rn_map_table #(.LOG_N(LOG_N), .TW(TW)) map_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (ren_lsrc_a),
        .rd_b_idx (ren_lsrc_b),
        .rd_c_idx (ren_ldst),
        .rd_a_tag (ren_psrc_a),
        .rd_b_tag (ren_psrc_b),
        .rd_c_tag (old_dst_tag),
        .wr_en    (ren_fire),
        .wr_idx   (ren_ldst),
        .wr_tag   (fl_head),
        .map_flat (map_flat)
    );

    rn_tag_fifo #(.DEPTH(POOL), .TW(TW), .INIT_FULL(1'b1), .INIT_BASE(LOG_N)) free_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ret_go),
        .push_tag (rq_head),
        .pop      (ren_fire),
        .head_tag (fl_head),
        .empty    (fl_empty),
        .full     (fl_full),
        .count    (fl_cnt)
    );

    rn_tag_fifo #(.DEPTH(POOL), .TW(TW), .INIT_FULL(1'b0), .INIT_BASE(0)) retq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ren_fire),
        .push_tag (old_dst_tag),
        .pop      (ret_go),
        .head_tag (rq_head),
        .empty    (rq_empty),
        .full     (rq_full),
        .count    (rq_cnt)
    );
endmodule

// File: rtl/rn_rename_checker.sv
module rn_rename_checker #(
    parameter int unsigned LOG_N  = 4,
    parameter int unsigned PHYS_N = 8,
    parameter int unsigned LW     = 2,
    parameter int unsigned TW     = 3,
    parameter int unsigned CW     = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ren_valid,
    input logic                ren_ready,
    input logic [LW-1:0]       ren_ldst,
    input logic [TW-1:0]       ren_psrc_a,
    input logic [TW-1:0]       ren_psrc_b,
    input logic [TW-1:0]       ren_pdst,
    input logic                ret_valid,
    input logic                fl_push,
    input logic                fl_full,
    input logic [CW-1:0]       fl_cnt,
    input logic [CW-1:0]       rq_cnt,
    input logic [LOG_N*TW-1:0] map_flat
);
    logic          last_fire;
    logic [LW-1:0] last_dst;
    logic [TW-1:0] last_tag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_fire <= 1'b0;
            last_dst  <= '0;
            last_tag  <= '0;
        end else begin
            last_fire <= ren_valid && ren_ready;
            last_dst  <= ren_ldst;
            last_tag  <= ren_pdst;
        end
    end

    AST_NEW_MAP_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        last_fire |-> map_flat[int'(last_dst)*TW +: TW] == last_tag); // R3

    AST_FRESH_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready) |-> (ren_pdst != ren_psrc_a && ren_pdst != ren_psrc_b)); // R2

    AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && !ren_ready && !ret_valid) |=> ($stable(map_flat) && $stable(fl_cnt))); // R8

    AST_NO_FREE_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fl_push |-> !fl_full); // R6

    AST_TAGS_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fl_cnt) + int'(rq_cnt)) == int'(PHYS_N - LOG_N)); // R5

    AST_IDLE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && rq_cnt == '0 && !ren_valid) |=> $stable(fl_cnt)); // R7
endmodule

bind reg_rename_unit rn_rename_checker #(
    .LOG_N (LOG_N),
    .PHYS_N(PHYS_N),
    .LW    (rn_pkg::rn_bits(LOG_N)),
    .TW    (TW),
    .CW    (CW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ren_valid (ren_valid),
    .ren_ready (ren_ready),
    .ren_ldst  (ren_ldst),
    .ren_psrc_a(ren_psrc_a),
    .ren_psrc_b(ren_psrc_b),
    .ren_pdst  (ren_pdst),
    .ret_valid (ret_valid),
    .fl_push   (ret_go),
    .fl_full   (fl_full),
    .fl_cnt    (fl_cnt),
    .rq_cnt    (rq_cnt),
    .map_flat  (map_flat)
);

// File: tb/reg_rename_unit_tb_top.sv
module reg_rename_unit_tb_top;
    localparam int LOG_N  = 4;
    localparam int PHYS_N = 8;
    localparam int LW     = 2;
    localparam int TW     = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ren_valid = 1'b0;
    logic [LW-1:0] ren_lsrc_a = '0, ren_lsrc_b = '0, ren_ldst = '0;
    logic          ren_ready;
    logic [TW-1:0] ren_psrc_a, ren_psrc_b, ren_pdst;
    logic          ret_valid = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    reg_rename_unit #(.LOG_N(LOG_N), .PHYS_N(PHYS_N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ren_valid (ren_valid),
        .ren_lsrc_a(ren_lsrc_a),
        .ren_lsrc_b(ren_lsrc_b),
        .ren_ldst  (ren_ldst),
        .ren_ready (ren_ready),
        .ren_psrc_a(ren_psrc_a),
        .ren_psrc_b(ren_psrc_b),
        .ren_pdst  (ren_pdst),
        .ret_valid (ret_valid)
    );

    typedef struct {
        string req;
        bit    rdy;
        bit    cmp_tags;
        int    pa;
        int    pb;
        int    pd;
    } exp_t;

    exp_t exp_q[$];

    // Reference model state
    int mdl_map[LOG_N];
    int mdl_free[$];
    int mdl_retq[$];

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the predicted outputs.
    task automatic step(bit v, int la, int lb, int ld, bit rv, string req);
        exp_t e;
        @(negedge clk);
        #1;
        ren_valid  = v;
        ren_lsrc_a = LW'(la);
        ren_lsrc_b = LW'(lb);
        ren_ldst   = LW'(ld);
        ret_valid  = rv;
        e.req      = req;
        e.rdy      = (mdl_free.size() > 0);
        e.cmp_tags = v && e.rdy;
        e.pa       = mdl_map[la];
        e.pb       = mdl_map[lb];
        e.pd       = e.rdy ? mdl_free[0] : 0;
        exp_q.push_back(e);
        if (e.cmp_tags) begin
            mdl_retq.push_back(mdl_map[ld]);
            mdl_map[ld] = e.pd;
            void'(mdl_free.pop_front());
        end
        if (rv && mdl_retq.size() > 0) begin
            mdl_free.push_back(mdl_retq.pop_front());
        end
    endtask

    // Monitor: samples between edges and compares against the queue.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.req, " ready"}, int'(ren_ready), int'(e.rdy));
                if (e.cmp_tags) begin
                    check({e.req, " psrc_a"}, int'(ren_psrc_a), e.pa);
                    check({e.req, " psrc_b"}, int'(ren_psrc_b), e.pb);
                    check({e.req, " pdst"},   int'(ren_pdst),   e.pd);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int lfsr;
        for (int i = 0; i < LOG_N; i++) mdl_map[i] = i;
        for (int i = LOG_N; i < PHYS_N; i++) mdl_free.push_back(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        step(1'b0, 0, 0, 0, 1'b1, "R1 R7 idle retire");    // nothing in flight
        step(1'b1, 1, 2, 1, 1'b0, "R1 R4 src equals dst"); // pdst 4, sources 1,2
        step(1'b1, 1, 0, 3, 1'b0, "R3 next cycle sees new");
        step(1'b1, 3, 3, 3, 1'b0, "R2 R4 double source");
        step(1'b1, 2, 1, 0, 1'b0, "R1 last initial tag");
        step(1'b1, 1, 3, 2, 1'b0, "R8 empty stall");
        step(1'b1, 0, 2, 1, 1'b0, "R8 stall again");
        step(1'b0, 0, 0, 0, 1'b1, "R6 retire oldest");
        step(1'b1, 1, 3, 2, 1'b0, "R8 R6 map kept, freed tag");
        step(1'b1, 0, 0, 0, 1'b1, "R9 same-cycle free not usable");
        step(1'b1, 0, 2, 0, 1'b1, "R9 freed tag usable next");
        step(1'b0, 0, 0, 0, 1'b1, "R6 drain");
        step(1'b0, 0, 0, 0, 1'b1, "R6 drain");
        step(1'b1, 2, 0, 1, 1'b1, "R5 fifo order");

        lfsr = 32'h1d5;
        for (int n = 0; n < 600; n++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            step(lfsr[0] | lfsr[5], (lfsr >> 1) & 3, (lfsr >> 3) & 3,
                 (lfsr >> 6) & 3, lfsr[8] & ~lfsr[9] | lfsr[10] & lfsr[11],
                 "R5 R6 R9 mixed");
        end
        for (int n = 0; n < 6; n++) step(1'b0, 0, 0, 0, 1'b1, "R6 final drain");
        step(1'b1, 3, 2, 1, 1'b0, "R5 after drain");
        @(negedge clk);
        #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule